// File: doc/BRIEF.md
# Half to Single Precision Widener

This block turns a 16-bit binary floating-point value (1 sign bit, 5 exponent bits, 10 fraction bits) into the 32-bit format with the same value (1 sign bit, 8 exponent bits, 23 fraction bits). Every 16-bit value fits exactly in the 32-bit format, so the block never rounds. It sorts the input into one of five classes and builds the result for each class. Inputs below the normal range come out as normal 32-bit values, placed by a leading-zero count of the fraction.

For NaN inputs a mode pin picks one of two results. Either the sign and the payload pass through with the quiet bit forced to 1, or a fixed canonical NaN replaces them. A signalling NaN input sets a sticky invalid flag. The flag stays set until the clear input is pulsed.

A parameter selects the output stage. With the default registered stage, a result appears one clock after its input strobe. With the combinational variant, the result follows the input within the same cycle. The field widths are parameters.

Top module: `h2s_widen`

## Requirements
- R1: An input with exponent field (bits 14:10) equal to 0 and fraction field (bits 9:0) equal to 0 produces a 32-bit zero with the input's sign in bit 31. An input of 0x0000 gives 0x00000000, and 0x8000 gives 0x80000000.
- R2: An input with exponent field 31 and fraction 0 produces an infinity with the input's sign: 0x7F800000 or 0xFF800000.
- R3: An input with exponent field 1 to 30 produces the same sign, the exponent field plus 112 in bits 30:23, and the 10 fraction bits in bits 22:13 with zeros below them.
- R4: An input with exponent field 0 and a nonzero fraction produces a normal result. Let z be the number of leading zeros of the 10-bit fraction. The exponent is 112 − z. The fraction bits that remain below the leading one are shifted up to the top of bits 22:13, and all lower bits are 0.
- R5: When the default-NaN pin is 0, an input with exponent field 31 and a nonzero fraction produces the input sign, exponent 0xFF, bit 22 set to 1, input fraction bits 8:0 in bits 21:13, and zeros below them.
- R6: When the default-NaN pin is 1, every NaN input produces 0x7FC00000.
- R7: A NaN input with fraction bit 9 equal to 0 (a signalling NaN), strobed by in_valid, sets inv_flag from the next clock edge on, in both NaN modes. A quiet NaN input, or any other input, does not set the flag.
- R8: inv_flag stays set until a cycle in which flag_clr is 1 and no signalling NaN is strobed. After that cycle it reads 0. If a clear and a signalling NaN arrive in the same cycle, the flag stays set.
- R9: In the registered variant, out_valid is the value of in_valid one clock earlier. out_single loads only on a strobe and holds its value otherwise.
- R10: After reset, out_valid, out_single and inv_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe that marks in_half as an operand |
| in_half | input | 16 | Half-precision operand |
| dflt_nan | input | 1 | 1: every NaN becomes the canonical NaN; 0: the NaN payload is kept |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Result strobe |
| out_single | output | 32 | Single-precision result |
| inv_flag | output | 1 | Sticky flag set by signalling NaN inputs |

## Verification
The hardest cases to reach are the rare collisions. One is a flag clear that arrives in the same cycle as a signalling NaN. Another is a long run of strobe gaps during which the output must hold. The bench sweeps all 65,536 encodings in both NaN modes. Strobe gaps and clear pulses come on two unrelated periods, so they fall across every input class. A directed sequence then forces the clear and the signalling NaN into the same cycle. A behavioural model checks the output on every clock. The model normalises small values by repeated doubling, not by counting zeros.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
   typedef enum logic [2:0] {
      CL_ZERO = 3'd0,
      CL_SUB  = 3'd1,
      CL_NORM = 3'd2,
      CL_INF  = 3'd3,
      CL_NAN  = 3'd4
   } fp_class_e;
endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
   import h2s_pkg::*;
#(
   parameter int EXP_IN = 5,
   parameter int MAN_IN = 10,
   localparam int IN_W  = 1 + EXP_IN + MAN_IN
) (
   input  logic [IN_W-1:0]   word,
   output logic              sgn,
   output logic [EXP_IN-1:0] ex_f,
   output logic [MAN_IN-1:0] man,
   output fp_class_e         cls,
   output logic              is_snan
);
   assign sgn  = word[IN_W-1];
   assign ex_f = word[IN_W-2 -: EXP_IN];
   assign man  = word[MAN_IN-1:0];

   always_comb begin
      if (ex_f == '0)
         cls = (man == '0) ? CL_ZERO : CL_SUB;
      else if (&ex_f)
         cls = (man == '0) ? CL_INF : CL_NAN;
      else
         cls = CL_NORM;
   end

   // top fraction bit clear means the NaN signals
   assign is_snan = (cls == CL_NAN) && !man[MAN_IN-1];
endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
   parameter int W  = 10,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   // scan upward; the highest set bit writes last and wins
   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) cnt = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/h2s_assemble.sv
module h2s_assemble
   import h2s_pkg::*;
#(
   parameter int EXP_IN  = 5,
   parameter int MAN_IN  = 10,
   parameter int EXP_OUT = 8,
   parameter int MAN_OUT = 23,
   localparam int LZW    = $clog2(MAN_IN + 1),
   localparam int OUT_W  = 1 + EXP_OUT + MAN_OUT,
   localparam int PAD    = MAN_OUT - MAN_IN,
   localparam int REBIAS = (2**(EXP_OUT-1) - 1) - (2**(EXP_IN-1) - 1)
) (
   input  logic              sgn,
   input  logic [EXP_IN-1:0] ex_f,
   input  logic [MAN_IN-1:0] man,
   input  fp_class_e         cls,
   input  logic [LZW-1:0]    lz,
   input  logic              dflt,
   output logic [OUT_W-1:0]  res
);
   logic [MAN_IN-1:0]  sub_frac;
   logic [MAN_OUT-1:0] nan_frac;
   logic [MAN_OUT-1:0] dnan_frac;

   // the leading one becomes the hidden bit and shifts out
   assign sub_frac = man << (int'(lz) + 1);

   always_comb begin
      nan_frac            = {man, {PAD{1'b0}}};
      nan_frac[MAN_OUT-1] = 1'b1;
      dnan_frac           = '0;
      dnan_frac[MAN_OUT-1] = 1'b1;
   end

   always_comb begin
      unique case (cls)
         CL_ZERO: res = {sgn, {EXP_OUT{1'b0}}, {MAN_OUT{1'b0}}};
         CL_INF:  res = {sgn, {EXP_OUT{1'b1}}, {MAN_OUT{1'b0}}};
         CL_NORM: res = {sgn, EXP_OUT'(ex_f) + EXP_OUT'(REBIAS),
                         man, {PAD{1'b0}}};
         CL_SUB:  res = {sgn, EXP_OUT'(REBIAS) - EXP_OUT'(lz),
                         sub_frac, {PAD{1'b0}}};
         CL_NAN:  res = dflt ? {1'b0, {EXP_OUT{1'b1}}, dnan_frac}
                             : {sgn, {EXP_OUT{1'b1}}, nan_frac};
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
   import h2s_pkg::*;
#(
   parameter int EXP_IN     = 5,
   parameter int MAN_IN     = 10,
   parameter int EXP_OUT    = 8,
   parameter int MAN_OUT    = 23,
   parameter bit REGISTERED = 1'b1,
   localparam int IN_W  = 1 + EXP_IN + MAN_IN,
   localparam int OUT_W = 1 + EXP_OUT + MAN_OUT,
   localparam int LZW   = $clog2(MAN_IN + 1),
   localparam int REBIAS = (2**(EXP_OUT-1) - 1) - (2**(EXP_IN-1) - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_half,
   input  logic             dflt_nan,
   input  logic             flag_clr,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_single,
   output logic             inv_flag
);
   if (EXP_OUT <= EXP_IN || MAN_OUT <= MAN_IN) begin : g_bad_cfg
      $error("h2s_widen: output fields must be wider than input fields");
   end

   localparam logic [OUT_W-1:0] DNAN = {1'b0, {EXP_OUT{1'b1}}, 1'b1, {(MAN_OUT-1){1'b0}}};

   logic              sgn;
   logic [EXP_IN-1:0] ex_f;
   logic [MAN_IN-1:0] man;
   fp_class_e         cls;
   logic              is_snan;
   logic [LZW-1:0]    lz;
   logic [OUT_W-1:0]  res;

   h2s_classify #(.EXP_IN(EXP_IN), .MAN_IN(MAN_IN)) u_cls (
      .word(in_half), .sgn(sgn), .ex_f(ex_f), .man(man),
      .cls(cls), .is_snan(is_snan)
   );

   h2s_lzc #(.W(MAN_IN)) u_lzc (.vec(man), .cnt(lz));

   h2s_assemble #(.EXP_IN(EXP_IN), .MAN_IN(MAN_IN),
                  .EXP_OUT(EXP_OUT), .MAN_OUT(MAN_OUT)) u_asm (
      .sgn(sgn), .ex_f(ex_f), .man(man), .cls(cls), .lz(lz),
      .dflt(dflt_nan), .res(res)
   );

   // sticky invalid flag: a new event wins over a clear
   logic flag_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   flag_q <= 1'b0;
      else if (in_valid && is_snan) flag_q <= 1'b1;
      else if (flag_clr)            flag_q <= 1'b0;
   end
   assign inv_flag = flag_q;

   p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_snan) |=> inv_flag);
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_flag && !flag_clr) |=> inv_flag);
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!inv_flag && !(in_valid && cls == CL_NAN)) |=> !inv_flag);

   if (REGISTERED) begin : g_reg
      logic             vld_q;
      logic [OUT_W-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            out_q <= '0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) out_q <= res;
         end
      end
      assign out_valid  = vld_q;
      assign out_single = out_q;

      p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(out_single)));
      p_dnan_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && dflt_nan && cls == CL_NAN) |=> (out_single == DNAN));
      p_sub_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cls == CL_SUB) |=>
            (out_single[OUT_W-2 -: EXP_OUT] <= EXP_OUT'(REBIAS) &&
             out_single[OUT_W-2 -: EXP_OUT] != '0));
   end else begin : g_comb
      assign out_valid  = in_valid;
      assign out_single = res;
   end
endmodule

// File: tb/h2s_widen_bench.sv
module h2s_widen_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [15:0] in_half;
   logic        dflt_nan;
   logic        flag_clr;
   logic        out_valid;
   logic [31:0] out_single;
   logic        inv_flag;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   h2s_widen u_h2s_widen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
      .dflt_nan(dflt_nan), .flag_clr(flag_clr), .out_valid(out_valid),
      .out_single(out_single), .inv_flag(inv_flag)
   );

   // model state: what the ports should show after the next edge
   logic        m_valid = 1'b0;
   logic [31:0] m_out   = '0;
   logic        m_flag  = 1'b0;
   string       m_tag   = "R10";
   string       f_tag   = "R10";

   function automatic logic [31:0] ref_conv(input logic [15:0] h, input logic dn);
      int e;
      int m;
      int ee;
      e = int'(h[14:10]);
      m = int'(h[9:0]);
      if (e == 0 && m == 0) return {h[15], 31'd0};
      if (e == 31 && m == 0) return {h[15], 8'hFF, 23'd0};
      if (e == 31) return dn ? 32'h7FC0_0000 : {h[15], 8'hFF, 1'b1, h[8:0], 13'd0};
      if (e == 0) begin
         ee = 113;
         while (m < 1024) begin
            m = m * 2;
            ee = ee - 1;
         end
         return {h[15], 8'(ee), 10'(m), 13'd0};
      end
      return {h[15], 8'(e + 112), h[9:0], 13'd0};
   endfunction

   function automatic string ref_tag(input logic [15:0] h, input logic dn);
      if (h[14:10] == 5'd0) return (h[9:0] == 10'd0) ? "R1" : "R4";
      if (h[14:10] == 5'd31) begin
         if (h[9:0] == 10'd0) return "R2";
         return dn ? "R6" : "R5";
      end
      return "R3";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic compare();
      chk("R9 out_valid", {31'd0, out_valid}, {31'd0, m_valid});
      chk(m_tag, out_single, m_out);
      chk(f_tag, {31'd0, inv_flag}, {31'd0, m_flag});
   endtask

   task automatic step(input logic v, input logic [15:0] h, input logic dn, input logic clr);
      logic snan;
      @(negedge clk);
      compare();
      in_valid = v;
      in_half  = h;
      dflt_nan = dn;
      flag_clr = clr;
      snan = (h[14:10] == 5'd31) && (h[9:0] != 10'd0) && !h[9];
      m_valid = v;
      if (v) begin
         m_out = ref_conv(h, dn);
         m_tag = ref_tag(h, dn);
      end else begin
         m_tag = "R9 hold";
      end
      f_tag  = (v && snan) ? "R7" : "R8";
      m_flag = (v && snan) ? 1'b1 : (clr ? 1'b0 : m_flag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_half = '0; dflt_nan = 1'b0; flag_clr = 1'b0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R10 out_single", out_single, 32'd0);
      chk("R10 inv_flag", {31'd0, inv_flag}, 32'd0);
      rst_n = 1'b1;

      // sweep every encoding, payload-keeping mode
      for (int i = 0; i < 65536; i++)
         step((i % 13) != 5, 16'(i), 1'b0, (i % 211) == 0);
      // sweep every encoding, canonical-NaN mode
      for (int i = 0; i < 65536; i++)
         step((i % 17) != 3, 16'(i), 1'b1, (i % 199) == 0);

      // R8: clear collides with a signalling NaN; flag stays set
      step(1'b1, 16'h7C01, 1'b0, 1'b1);
      step(1'b1, 16'hFE00, 1'b0, 1'b0);   // quiet NaN: no new event (R7)
      step(1'b0, 16'h0000, 1'b0, 1'b1);   // clear alone drops the flag
      step(1'b0, 16'h1234, 1'b0, 1'b0);   // R9: output holds across gaps
      step(1'b0, 16'h4321, 1'b1, 1'b0);
      // directed spot values: R3 one, R4 smallest subnormal, R1 negative zero
      step(1'b1, 16'h3C00, 1'b0, 1'b0);
      step(1'b1, 16'h0001, 1'b0, 1'b0);
      step(1'b1, 16'h8000, 1'b0, 1'b0);
      step(1'b1, 16'hFC00, 1'b0, 1'b0);   // R2 negative infinity
      step(1'b0, 16'h0000, 1'b0, 1'b0);
      @(negedge clk);
      compare();
      chk("R4 spot 0x0001", ref_conv(16'h0001, 1'b0), 32'h3380_0000);
      chk("R3 spot 0x3C00", ref_conv(16'h3C00, 1'b0), 32'h3F80_0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule